// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block keeps, for each of several hotplug-capable buses, a word of slots waiting to be brought up and a word of slots waiting to be torn down. Hardware raises single-cycle plug and unplug requests naming a bus and a slot. Each request that counts sets a pending bit and produces a one-cycle event pulse for the interrupt controller. Software reaches the block through a 20-byte window of 32-bit registers. A select register decides which bus's words the window shows. Software reads the pending words and acknowledges a removal by writing an eject mask.

The insert word clears itself when it is read. An eject write acts on one slot only: the lowest set bit of the data. A legacy strap stops the insert word from clearing on read and holds the selection on a fixed default bus. A removable-slot word per bus is built from per-slot capability inputs. This happens after the register reset and again after each hotplug reset request. In both cases a sequencer first walks every bus and retires the pending removals one slot per cycle.

Top module: `hp_status_bank`

## Requirements
- R1: A read access gets `rd_valid` high in the next cycle. `rd_data` then holds the read word. Offset 0x04 gives the selected bus's remove-pending word, 0x0C its removable word, 0x08 always zero, and 0x10 the select value.
- R2: A read of offset 0x00 returns the selected bus's insert-pending word and clears that word in the same access. With `legacy_mode` high the read leaves the word unchanged.
- R3: The select value is taken as an unsigned 32-bit number. When it is not below NB (which includes every negative value), each read returns zero and an eject write changes nothing.
- R4: A write to 0x08 takes the lowest set bit of the data as the slot number. It clears that slot in both the insert and remove words of the selected bus. Higher set bits are ignored, and all-zero data does nothing.
- R5: A write to 0x10 loads the select register. With `legacy_mode` high the register is loaded with DEF_BUS instead. The register reset value is DEF_BUS.
- R6: A plug request with `plug_boot` low sets bit `plug_slot` of bus `plug_bus`'s insert word, and `hp_event` is high in the next cycle. With `plug_boot` high the request sets nothing and raises no event.
- R7: An unplug request sets bit `unplug_slot` of bus `unplug_bus`'s remove word, and `hp_event` is high in the next cycle.
- R8: If a set lands on the same cycle as a read-clear or an eject clear of the same bit, the bit ends up set.
- R9: These accesses are ignored: writes to 0x00, 0x04 or 0x0C, and any access whose address is not a multiple of 4 or is 0x14 or above. Such a read returns zero.
- R10: After reset, and after each `hp_reset_req` pulse, the drain sequence runs. It walks the buses from bus 0 upward and holds `drain_busy` high for one cycle per pending remove bit plus one per bus. Each drain cycle clears the lowest pending remove slot of the current bus in both of that bus's words.
- R11: When the drain sequence finishes a bus, the bus's removable word becomes all ones with the bits set in its part of `slot_fixed` cleared. Bus b uses bits [b*SLOTS +: SLOTS].
- R12: A plug or unplug request whose bus number is not below NB changes no state and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Strap: no clear on insert read, selection pinned to DEF_BUS |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| plug_valid | input | 1 | Plug request |
| plug_bus | input | IDX_W | Bus of the plug request |
| plug_slot | input | SLOT_W | Slot of the plug request |
| plug_boot | input | 1 | Device present at boot, no event |
| unplug_valid | input | 1 | Unplug request |
| unplug_bus | input | IDX_W | Bus of the unplug request |
| unplug_slot | input | SLOT_W | Slot of the unplug request |
| slot_fixed | input | NB*SLOTS | Per-slot flag: slot cannot be removed |
| hp_reset_req | input | 1 | Starts the drain and removable rebuild |
| hp_event | output | 1 | One-cycle hotplug event |
| drain_busy | output | 1 | Drain sequence running |

## Verification
The bench builds the block with NB = 3, SLOTS = 32 and DEF_BUS = 1. Three buses make the two-bit bus field able to name bus 3, which does not exist, so the ignored requests of R12 can be driven. A default bus away from zero makes the pinned selection of legacy mode visible. With full 32-slot words, eject data with several bits set shows that only the lowest bit acts. The drain length is summed over three buses with different pending counts.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
// Shared register offsets and helpers for the hotplug status bank.
package hp_pkg;
    localparam logic [4:0] OFS_INS  = 5'h00;  // insert-pending word, cleared on read
    localparam logic [4:0] OFS_REM  = 5'h04;  // remove-pending word
    localparam logic [4:0] OFS_EJ   = 5'h08;  // eject write, reads zero
    localparam logic [4:0] OFS_RMV  = 5'h0C;  // removable-slot word
    localparam logic [4:0] OFS_SEL  = 5'h10;  // bus select
    localparam logic [4:0] WIN_END  = 5'h14;  // first offset outside window

    // Isolates the lowest set bit of a 32-bit word.
    function automatic logic [31:0] low_bit32(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction
endpackage

// File: rtl/hp_bus_slice.sv
`timescale 1ns/1ps
// Per-bus pending words. Clears are applied before sets, so a set in the
// same cycle wins. Assumes clr_vec and set_* are already gated to this bus.
module hp_bus_slice #(
    parameter int SLOTS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_ins,
    input  logic [SLOTS-1:0] clr_vec,
    input  logic [SLOTS-1:0] set_ins,
    input  logic [SLOTS-1:0] set_rem,
    input  logic             ld_rmv,
    input  logic [SLOTS-1:0] fixed,
    output logic [SLOTS-1:0] ins_q,
    output logic [SLOTS-1:0] rem_q,
    output logic [SLOTS-1:0] rmv_q
);
    logic [SLOTS-1:0] ins_keep;

    // Insert bits that survive this cycle's read-clear.
    always_comb ins_keep = clr_ins ? '0 : ins_q;

    // Update the three words: clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_q <= '0;
            rem_q <= '0;
            rmv_q <= '1;
        end else begin
            ins_q <= (ins_keep & ~clr_vec) | set_ins;
            rem_q <= (rem_q & ~clr_vec) | set_rem;
            if (ld_rmv) rmv_q <= ~fixed;
        end
    end
endmodule

// File: rtl/hp_drain_seq.sv
`timescale 1ns/1ps
// Drain sequencer: walks buses 0..NB-1 and retires one pending remove slot
// per cycle. When a bus has none left it loads that bus's removable word and
// moves on. Starts after reset and on start.
module hp_drain_seq #(
    parameter int NB    = 3,
    parameter int SLOTS = 32,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NB*SLOTS-1:0] rem_flat,
    output logic                busy,
    output logic [NB*SLOTS-1:0] clr_flat,
    output logic [NB-1:0]       ld_vec
);
    logic [IDX_W-1:0] idx;
    logic [SLOTS-1:0] cur;

    // Remove word of the bus being drained.
    always_comb cur = rem_flat[idx*SLOTS +: SLOTS];

    // One step: clear the lowest pending slot, or finish the bus.
    always_comb begin
        clr_flat = '0;
        ld_vec   = '0;
        if (busy) begin
            if (cur != '0) clr_flat[idx*SLOTS +: SLOTS] = cur & (~cur + 1'b1);
            else           ld_vec[idx] = 1'b1;
        end
    end

    // Bus pointer and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy && cur == '0) begin
            if (int'(idx) == NB - 1) busy <= 1'b0;
            else                     idx  <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/hp_reg_if.sv
`timescale 1ns/1ps
// Register front end: decodes the window, holds the select register, forms the
// registered read response and the read-clear and eject strobes. Assumes one
// access per cycle.
module hp_reg_if
    import hp_pkg::*;
#(
    parameter int NB      = 3,
    parameter int SLOTS   = 32,
    parameter int DEF_BUS = 0,
    localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                legacy_mode,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [4:0]          req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [NB*SLOTS-1:0] ins_flat,
    input  logic [NB*SLOTS-1:0] rem_flat,
    input  logic [NB*SLOTS-1:0] rmv_flat,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic [31:0]         sel_q,
    output logic [IDX_W-1:0]    sel_idx,
    output logic                rd_clr_ins,
    output logic [SLOTS-1:0]    ej_vec
);
    logic             in_win, sel_ok, rd_hit, wr_hit;
    logic [IDX_W-1:0] sel_safe;
    logic [31:0]      rd_word, ej_low;

    // Address and selection qualification.
    always_comb begin
        in_win   = (req_addr[1:0] == 2'b00) && (req_addr < WIN_END);
        sel_ok   = sel_q < NB;
        sel_idx  = sel_q[IDX_W-1:0];
        sel_safe = sel_ok ? sel_idx : '0;
        rd_hit   = req_valid && !req_write && in_win && sel_ok;
        wr_hit   = req_valid && req_write && in_win;
    end

    // Read-clear and eject strobes toward the selected bus.
    always_comb begin
        ej_low     = low_bit32(req_wdata);
        rd_clr_ins = rd_hit && (req_addr == OFS_INS) && !legacy_mode;
        ej_vec     = (wr_hit && (req_addr == OFS_EJ) && sel_ok) ? ej_low[SLOTS-1:0] : '0;
    end

    // Read multiplexer over the selected bus's words.
    always_comb begin
        rd_word = '0;
        case (req_addr)
            OFS_INS: rd_word = 32'(ins_flat[sel_safe*SLOTS +: SLOTS]);
            OFS_REM: rd_word = 32'(rem_flat[sel_safe*SLOTS +: SLOTS]);
            OFS_RMV: rd_word = 32'(rmv_flat[sel_safe*SLOTS +: SLOTS]);
            OFS_SEL: rd_word = sel_q;
            default: rd_word = '0;
        endcase
    end

    // Select register and registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 32'(DEF_BUS);
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (wr_hit && req_addr == OFS_SEL)
                sel_q <= legacy_mode ? 32'(DEF_BUS) : req_wdata;
            rd_valid <= req_valid && !req_write;
            rd_data  <= rd_hit ? rd_word : '0;
        end
    end
endmodule

// File: rtl/hp_status_bank.sv
`timescale 1ns/1ps
// Hotplug slot status bank: NB per-bus slices, the register front end and the
// drain sequencer. Plug and unplug requests set pending bits and pulse
// hp_event one cycle later. Assumes requests are single-cycle strobes.
module hp_status_bank #(
    parameter int NB      = 3,
    parameter int SLOTS   = 32,
    parameter int DEF_BUS = 0,
    localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                legacy_mode,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [4:0]          req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    input  logic                plug_valid,
    input  logic [IDX_W-1:0]    plug_bus,
    input  logic [SLOT_W-1:0]   plug_slot,
    input  logic                plug_boot,
    input  logic                unplug_valid,
    input  logic [IDX_W-1:0]    unplug_bus,
    input  logic [SLOT_W-1:0]   unplug_slot,
    input  logic [NB*SLOTS-1:0] slot_fixed,
    input  logic                hp_reset_req,
    output logic                hp_event,
    output logic                drain_busy
);
    logic [NB*SLOTS-1:0] ins_flat, rem_flat, rmv_flat, drain_clr;
    logic [NB-1:0]       drain_ld;
    logic [31:0]         sel_q;
    logic [IDX_W-1:0]    sel_idx;
    logic                rd_clr_ins, plug_hit, unplug_hit;
    logic [SLOTS-1:0]    ej_vec;

    // Requests that count: real bus, and for plugs not present at boot.
    always_comb begin
        plug_hit   = plug_valid && !plug_boot && (int'(plug_bus) < NB);
        unplug_hit = unplug_valid && (int'(unplug_bus) < NB);
    end

    hp_reg_if #(.NB(NB), .SLOTS(SLOTS), .DEF_BUS(DEF_BUS)) u_regs (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .ins_flat(ins_flat), .rem_flat(rem_flat),
        .rmv_flat(rmv_flat), .rd_valid(rd_valid), .rd_data(rd_data),
        .sel_q(sel_q), .sel_idx(sel_idx), .rd_clr_ins(rd_clr_ins), .ej_vec(ej_vec)
    );

    hp_drain_seq #(.NB(NB), .SLOTS(SLOTS)) u_drain (
        .clk(clk), .rst_n(rst_n), .start(hp_reset_req), .rem_flat(rem_flat),
        .busy(drain_busy), .clr_flat(drain_clr), .ld_vec(drain_ld)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bus
        logic             on_sel;
        logic [SLOTS-1:0] set_i, set_r, clr_v;

        // Route strobes that target bus b.
        always_comb begin
            on_sel = (int'(sel_idx) == b);
            set_i  = (plug_hit && int'(plug_bus) == b) ? (SLOTS'(1) << plug_slot) : '0;
            set_r  = (unplug_hit && int'(unplug_bus) == b) ? (SLOTS'(1) << unplug_slot) : '0;
            clr_v  = drain_clr[b*SLOTS +: SLOTS] | (on_sel ? ej_vec : '0);
        end

        hp_bus_slice #(.SLOTS(SLOTS)) u_slice (
            .clk(clk), .rst_n(rst_n), .clr_ins(rd_clr_ins && on_sel),
            .clr_vec(clr_v), .set_ins(set_i), .set_rem(set_r),
            .ld_rmv(drain_ld[b]), .fixed(slot_fixed[b*SLOTS +: SLOTS]),
            .ins_q(ins_flat[b*SLOTS +: SLOTS]), .rem_q(rem_flat[b*SLOTS +: SLOTS]),
            .rmv_q(rmv_flat[b*SLOTS +: SLOTS])
        );
    end

    // One-cycle event pulse per cycle with a counted request.
    always_ff @(posedge clk) begin
        if (!rst_n) hp_event <= 1'b0;
        else        hp_event <= plug_hit || unplug_hit;
    end
endmodule

// File: rtl/hp_status_bank_chk.sv
`timescale 1ns/1ps
// Property checker for hp_status_bank, attached by bind. Watches ports and the
// select register only.
module hp_status_bank_chk
    import hp_pkg::*;
#(
    parameter int NB      = 3,
    parameter int DEF_BUS = 0,
    localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             legacy_mode,
    input logic             req_valid,
    input logic             req_write,
    input logic [4:0]       req_addr,
    input logic             rd_valid,
    input logic [31:0]      rd_data,
    input logic             plug_valid,
    input logic [IDX_W-1:0] plug_bus,
    input logic             plug_boot,
    input logic             unplug_valid,
    input logic [IDX_W-1:0] unplug_bus,
    input logic             hp_reset_req,
    input logic             hp_event,
    input logic             drain_busy,
    input logic [31:0]      sel_q
);
    assert_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);
    assert_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
    assert_oor_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel_q >= NB) |=> rd_data == 32'd0);
    assert_legacy_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_SEL && legacy_mode) |=> sel_q == 32'(DEF_BUS));
    assert_plug_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_valid && !plug_boot && int'(plug_bus) < NB) |=> hp_event);
    assert_unplug_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug_valid && int'(unplug_bus) < NB) |=> hp_event);
    assert_bad_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr[1:0] != 2'b00 || req_addr >= WIN_END)) |=> rd_data == 32'd0);
    assert_drain_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hp_reset_req |=> drain_busy);
    assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !((plug_valid && !plug_boot && int'(plug_bus) < NB) || (unplug_valid && int'(unplug_bus) < NB))
        |=> !hp_event);
endmodule

bind hp_status_bank hp_status_bank_chk #(.NB(NB), .DEF_BUS(DEF_BUS)) u_chk (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_boot(plug_boot),
    .unplug_valid(unplug_valid), .unplug_bus(unplug_bus), .hp_reset_req(hp_reset_req),
    .hp_event(hp_event), .drain_busy(drain_busy), .sel_q(sel_q)
);

// File: tb/tb_hp_status_bank.sv
`timescale 1ns/1ps
// Bench: directed stimulus, a behavioural per-clock reference model, and
// hand-computed expectations for the corner cases.
module tb_hp_status_bank;
    localparam int NB = 3, SL = 32, DEF = 1;

    logic clk = 1'b0, rst_n = 1'b0, legacy_mode = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid, hp_event, drain_busy;
    logic [31:0] rd_data;
    logic plug_valid = 1'b0, plug_boot = 1'b0, unplug_valid = 1'b0, hp_reset_req = 1'b0;
    logic [1:0] plug_bus = '0, unplug_bus = '0;
    logic [4:0] plug_slot = '0, unplug_slot = '0;
    logic [NB*SL-1:0] slot_fixed = {32'h0000_0000, 32'h8000_0000, 32'h0000_0003};

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    hp_status_bank #(.NB(NB), .SLOTS(SL), .DEF_BUS(DEF)) dut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .plug_valid(plug_valid),
        .plug_bus(plug_bus), .plug_slot(plug_slot), .plug_boot(plug_boot),
        .unplug_valid(unplug_valid), .unplug_bus(unplug_bus), .unplug_slot(unplug_slot),
        .slot_fixed(slot_fixed), .hp_reset_req(hp_reset_req), .hp_event(hp_event),
        .drain_busy(drain_busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int low_idx(input logic [31:0] v);
        for (int k = 0; k < 32; k++) if (v[k]) return k;
        return -1;
    endfunction

    // ---------------- reference model ----------------
    logic [31:0] m_ins[NB], m_rem[NB], m_rmv[NB];
    logic [31:0] m_sel, m_rd;
    bit m_busy, m_ev, m_rdv;
    int m_di;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin m_ins[i] = 0; m_rem[i] = 0; m_rmv[i] = '1; end
            m_sel = DEF; m_busy = 1; m_di = 0; m_ev = 0; m_rdv = 0; m_rd = 0;
        end else begin
            logic [31:0] old_rem;
            bit ok, win;
            int s;
            ok = m_sel < NB;
            win = (req_addr[1:0] == 0) && (req_addr < 5'h14);
            old_rem = m_rem[m_di];
            m_rdv = req_valid && !req_write;
            m_rd = 0;
            if (req_valid && !req_write && win && ok) begin
                case (req_addr)
                    5'h00: begin m_rd = m_ins[m_sel]; if (!legacy_mode) m_ins[m_sel] = 0; end
                    5'h04: m_rd = m_rem[m_sel];
                    5'h0C: m_rd = m_rmv[m_sel];
                    5'h10: m_rd = m_sel;
                    default: m_rd = 0;
                endcase
            end
            if (req_valid && req_write && win) begin
                if (req_addr == 5'h08 && ok && req_wdata != 0) begin
                    s = low_idx(req_wdata);
                    m_ins[m_sel][s] = 0; m_rem[m_sel][s] = 0;
                end
                if (req_addr == 5'h10) m_sel = legacy_mode ? DEF : req_wdata;
            end
            if (m_busy) begin
                if (old_rem != 0) begin
                    s = low_idx(old_rem);
                    m_ins[m_di][s] = 0; m_rem[m_di][s] = 0;
                end else begin
                    m_rmv[m_di] = ~slot_fixed[m_di*SL +: SL];
                    if (m_di == NB - 1) m_busy = 0; else m_di++;
                end
            end
            if (hp_reset_req) begin m_busy = 1; m_di = 0; end
            m_ev = 0;
            if (plug_valid && !plug_boot && plug_bus < NB) begin m_ins[plug_bus][plug_slot] = 1; m_ev = 1; end
            if (unplug_valid && unplug_bus < NB) begin m_rem[unplug_bus][unplug_slot] = 1; m_ev = 1; end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_valid == m_rdv, "R1 rd_valid", 32'(rd_valid), 32'(m_rdv));
            if (m_rdv) chk(rd_data == m_rd, "R1 rd_data model", rd_data, m_rd);
            chk(hp_event == m_ev, "R6/R7 hp_event model", 32'(hp_event), 32'(m_ev));
            chk(drain_busy == m_busy, "R10 drain_busy model", 32'(drain_busy), 32'(m_busy));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk); req_valid = 0;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk); req_valid = 0; req_write = 0;
    endtask

    task automatic plug(input logic [1:0] b, input logic [4:0] s, input bit boot, input bit exp_ev, input string tag);
        @(negedge clk); plug_valid = 1; plug_bus = b; plug_slot = s; plug_boot = boot;
        @(negedge clk); plug_valid = 0; plug_boot = 0;
        chk(hp_event == exp_ev, tag, 32'(hp_event), 32'(exp_ev));
    endtask

    task automatic unplug(input logic [1:0] b, input logic [4:0] s, input bit exp_ev, input string tag);
        @(negedge clk); unplug_valid = 1; unplug_bus = b; unplug_slot = s;
        @(negedge clk); unplug_valid = 0;
        chk(hp_event == exp_ev, tag, 32'(hp_event), 32'(exp_ev));
    endtask

    task automatic wait_drain(output int n);
        n = 0;
        while (drain_busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(rd_valid == 0 && hp_event == 0, "R1 reset outputs", {rd_valid, hp_event}, 0);
        chk(drain_busy == 1, "R10 busy in reset", 32'(drain_busy), 1);
        rst_n = 1;
        wait_drain(n);
        chk(n == 3, "R10 drain length after reset", n, 3);
        rd(5'h10, 32'd1, "R5 select reset value");
        rd(5'h0C, 32'h7FFF_FFFF, "R11 removable bus1");

        plug(1, 5, 0, 1, "R6 plug event");
        rd(5'h00, 32'h20, "R2 insert read");
        rd(5'h00, 32'h0, "R2 insert cleared by read");
        plug(1, 6, 1, 0, "R6 boot plug no event");
        rd(5'h00, 32'h0, "R6 boot plug sets nothing");

        unplug(1, 3, 1, "R7 unplug event");
        unplug(1, 7, 1, "R7 unplug event");
        rd(5'h04, 32'h88, "R7 remove word");
        plug(1, 3, 0, 1, "R6 plug event");
        wr(5'h08, 32'h88);
        rd(5'h04, 32'h80, "R4 eject lowest bit only");
        rd(5'h00, 32'h0, "R4 eject clears insert bit");
        wr(5'h08, 32'h0);
        rd(5'h04, 32'h80, "R4 zero eject no effect");

        wr(5'h04, 32'h0);
        rd(5'h04, 32'h80, "R9 write to remove word ignored");
        wr(5'h00, 32'hFFFF);
        rd(5'h00, 32'h0, "R9 write to insert word ignored");
        wr(5'h0C, 32'h0);
        rd(5'h0C, 32'h7FFF_FFFF, "R9 write to removable word ignored");
        wr(5'h11, 32'd2);
        rd(5'h10, 32'd1, "R9 unaligned select write ignored");
        rd(5'h14, 32'h0, "R9 read outside window");
        rd(5'h12, 32'h0, "R9 unaligned read");
        rd(5'h08, 32'h0, "R1 eject offset reads zero");

        wr(5'h10, 32'd0);
        rd(5'h0C, 32'hFFFF_FFFC, "R11 removable bus0");
        rd(5'h04, 32'h0, "R1 remove word bus0");
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, 32'h0, "R3 negative select reads zero");
        wr(5'h08, 32'h80);
        wr(5'h10, 32'd3);
        rd(5'h10, 32'h0, "R3 select equal to bus count reads zero");
        wr(5'h10, 32'd1);
        rd(5'h04, 32'h80, "R3 eject with bad select ignored");

        plug(3, 0, 0, 0, "R12 plug on missing bus");
        unplug(3, 0, 0, "R12 unplug on missing bus");
        rd(5'h00, 32'h0, "R12 nothing set");

        plug(1, 2, 0, 1, "R6 plug event");
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 5'h00;
        plug_valid = 1; plug_bus = 1; plug_slot = 9;
        @(negedge clk);
        req_valid = 0; plug_valid = 0;
        chk(rd_data == 32'h4, "R8 read returns pre-set word", rd_data, 32'h4);
        rd(5'h00, 32'h200, "R8 set wins over read clear");
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 5'h08; req_wdata = 32'h80;
        unplug_valid = 1; unplug_bus = 1; unplug_slot = 7;
        @(negedge clk);
        req_valid = 0; req_write = 0; unplug_valid = 0;
        rd(5'h04, 32'h80, "R8 set wins over eject");

        legacy_mode = 1;
        wr(5'h10, 32'd2);
        rd(5'h10, 32'd1, "R5 legacy pins select");
        plug(1, 4, 0, 1, "R6 plug event");
        rd(5'h00, 32'h10, "R2 legacy read");
        rd(5'h00, 32'h10, "R2 legacy read does not clear");
        legacy_mode = 0;
        rd(5'h00, 32'h10, "R2 read after legacy");

        unplug(0, 1, 1, "R7 unplug event");
        unplug(0, 4, 1, "R7 unplug event");
        unplug(2, 0, 1, "R7 unplug event");
        plug(0, 1, 0, 1, "R6 plug event");
        @(negedge clk); hp_reset_req = 1;
        @(negedge clk); hp_reset_req = 0;
        wait_drain(n);
        chk(n == 7, "R10 drain length after request", n, 7);
        wr(5'h10, 32'd0);
        rd(5'h00, 32'h0, "R10 drain clears insert bit");
        rd(5'h04, 32'h0, "R10 drain empties bus0");
        rd(5'h0C, 32'hFFFF_FFFC, "R11 removable rebuilt bus0");
        wr(5'h10, 32'd1);
        rd(5'h04, 32'h0, "R10 drain empties bus1");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule